// File: doc/BRIEF.md
# Interruptible Load/Store Memory Sequencer

This controller issues the memory requests for a streaming per-site compute pipeline. For each site it fetches eight 32-bit conditional-likelihood values, four from a left array and four from a right array, plus one log-scaler word and one site-count word. It does this in three load phases of two requests each. The controller only sequences the request stream. Returned data goes into two operand FIFOs, and results come back out through output FIFOs. Both sets of FIFOs sit outside this block.

Loading runs as one long burst. When the output FIFOs report almost full, the burst is cut at the next request boundary and the controller writes the output FIFOs to memory until they are empty. It then resumes loading at exactly the request that was next. When every load has been accepted, a final drain empties what remains, the controller returns to idle and pulses `done`. Draining whole buffers at once keeps changes of bus direction rare.

Top module: `plfLoadStoreSeq`

## Requirements
- R1: During reset and while idle, `reqValid` and `done` stay low, whatever the FIFO status inputs show.
- R2: Each site k produces six accepted loads, always in this order: left+16k, left+16k+8, right+16k, right+16k+8, scale+4k, count+4k. The +8 entries are the second 64-bit word of that site's 16-byte slot, and `reqWrite` is 0 on every load. After site k the sequence continues with site k+1.
- R3: A request that is valid while `reqStall` is high stays valid in the next cycle, with the same `reqAddr` and the same `reqWrite`.
- R4: While either bit of `opFull` is high, no new load is presented. Only a load already held by a stall may continue.
- R5: While `outAlmostFull` is high, no new load is presented. The load sequence is suspended and writes begin. When the output FIFOs fill before the last site, at least one write is accepted before the last load.
- R6: Writes are presented only while `outEmpty` is low, apart from a write already held by a stall. The n-th accepted write since `start` goes to result+16n, and the count continues across separate drains.
- R7: After a drain, loading resumes at the first load not yet accepted. No load is ever accepted twice or skipped.
- R8: After the last load, the remaining results are written out. The controller then returns to idle and raises `done` for exactly one cycle, once all loads and writes are complete.
- R9: A `start` with a site count of 0 produces no loads and no writes, and still pulses `done`.
- R10: `start`, `siteCount` and the base addresses are sampled only when `start` arrives while idle. A `start` or a changed `siteCount` during a run has no effect on the request stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| siteCount | input | SITE_W | Number of sites in the run |
| baseLeft | input | ADDR_W | Byte base of the left conditional-likelihood array |
| baseRight | input | ADDR_W | Byte base of the right conditional-likelihood array |
| baseScale | input | ADDR_W | Byte base of the log-scaler array |
| baseCount | input | ADDR_W | Byte base of the site-count array |
| baseResult | input | ADDR_W | Byte base of the result area |
| reqValid | output | 1 | Memory request present |
| reqWrite | output | 1 | 1 = write (drain), 0 = load |
| reqAddr | output | ADDR_W | Byte address of the request |
| reqStall | input | 1 | Memory side refuses the request this cycle |
| opFull | input | 2 | Per-operand-FIFO flag: no room for further returns |
| outAlmostFull | input | 1 | Output FIFOs near capacity |
| outEmpty | input | 1 | Output FIFOs hold no results |
| done | output | 1 | One-cycle pulse on return to idle |

## Verification
The assertions take three things for granted about the inputs. `outEmpty` and `outAlmostFull` never hold at the same time. The output FIFO level only grows when a site completes and only shrinks when a write is accepted. The memory side treats any cycle with valid high and stall low as acceptance. The bench's model of the output FIFO follows these rules directly: each site whose last load is accepted adds one result, each accepted write removes one, and the almost-full flag is a threshold on that level. Stall and operand-full patterns rotate freely, including stalls that land on the cycle where almost-full rises. This exercises the rule that a held request outranks an interruption.

// File: rtl/seqPkg.sv
package seqPkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LD1   = 3'd1,
    ST_LD2   = 3'd2,
    ST_LD3   = 3'd3,
    ST_DRAIN = 3'd4,
    ST_FINAL = 3'd5
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      latch;     // capture run parameters, clear counters
    logic      wordAdv;   // a load was accepted
    logic      siteAdv;   // last load of a site was accepted
    logic      storeAdv;  // a write was accepted
    seqState_t sel;       // which address to present
  } seqStrobe_t;
endpackage

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SITE_W      = 16,
  parameter int FLOAT_BYTES = 4,
  parameter int LANES       = 4,
  parameter int BUS_BYTES   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [SITE_W-1:0] siteCountIn,
  input  logic [ADDR_W-1:0] baseLeftIn,
  input  logic [ADDR_W-1:0] baseRightIn,
  input  logic [ADDR_W-1:0] baseScaleIn,
  input  logic [ADDR_W-1:0] baseCountIn,
  input  logic [ADDR_W-1:0] baseResultIn,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              lastWord,
  output logic              lastSite,
  output logic              startEmpty
);
  localparam int CL_STRIDE  = FLOAT_BYTES * LANES;
  localparam int RES_STRIDE = 2 * BUS_BYTES;

  logic [ADDR_W-1:0] baseLeft, baseRight, baseScale, baseCount, baseResult;
  logic [SITE_W-1:0] count, site;
  logic              wordIdx;
  logic [ADDR_W-1:0] storeIdx;
  logic [ADDR_W-1:0] siteExt, clOff, scOff, wordOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseLeft   <= '0;
      baseRight  <= '0;
      baseScale  <= '0;
      baseCount  <= '0;
      baseResult <= '0;
      count      <= '0;
      site       <= '0;
      wordIdx    <= 1'b0;
      storeIdx   <= '0;
    end else if (strobe.latch) begin
      baseLeft   <= baseLeftIn;
      baseRight  <= baseRightIn;
      baseScale  <= baseScaleIn;
      baseCount  <= baseCountIn;
      baseResult <= baseResultIn;
      count      <= siteCountIn;
      site       <= '0;
      wordIdx    <= 1'b0;
      storeIdx   <= '0;
    end else begin
      if (strobe.wordAdv)  wordIdx  <= ~wordIdx;
      if (strobe.siteAdv)  site     <= site + 1'b1;
      if (strobe.storeAdv) storeIdx <= storeIdx + 1'b1;
    end
  end

  always_comb begin
    siteExt = ADDR_W'(site);
    clOff   = siteExt * ADDR_W'(CL_STRIDE);
    scOff   = siteExt * ADDR_W'(FLOAT_BYTES);
    wordOff = wordIdx ? ADDR_W'(BUS_BYTES) : '0;
    unique case (strobe.sel)
      ST_LD1:   reqAddr = baseLeft + clOff + wordOff;
      ST_LD2:   reqAddr = baseRight + clOff + wordOff;
      ST_LD3:   reqAddr = wordIdx ? (baseCount + scOff) : (baseScale + scOff);
      ST_DRAIN,
      ST_FINAL: reqAddr = baseResult + storeIdx * ADDR_W'(RES_STRIDE);
      default:  reqAddr = '0;
    endcase
  end

  assign lastWord   = wordIdx;
  assign lastSite   = (SITE_W'(site + 1'b1) == count);
  assign startEmpty = (siteCountIn == '0);
endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       reqStall,
  input  logic [1:0] opFull,
  input  logic       outAlmostFull,
  input  logic       outEmpty,
  input  logic       lastWord,
  input  logic       lastSite,
  input  logic       startEmpty,
  output seqStrobe_t strobe,
  output logic       reqValid,
  output logic       reqWrite,
  output logic       done
);
  seqState_t state, stateNext, resumeState;
  logic      holding;     // last cycle's request was stalled
  logic      saveResume;
  logic      accept;

  always_comb begin
    strobe     = '0;
    strobe.sel = state;
    stateNext  = state;
    reqValid   = 1'b0;
    reqWrite   = 1'b0;
    saveResume = 1'b0;
    accept     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.latch = 1'b1;
          stateNext    = startEmpty ? ST_FINAL : ST_LD1;
        end
      end
      ST_LD1, ST_LD2, ST_LD3: begin
        if (!holding && outAlmostFull) begin
          saveResume = 1'b1;
          stateNext  = ST_DRAIN;
        end else begin
          reqValid = holding || !(|opFull);
          accept   = reqValid && !reqStall;
          if (accept) begin
            strobe.wordAdv = 1'b1;
            if (lastWord) begin
              if (state == ST_LD1)      stateNext = ST_LD2;
              else if (state == ST_LD2) stateNext = ST_LD3;
              else begin
                strobe.siteAdv = 1'b1;
                stateNext      = lastSite ? ST_FINAL : ST_LD1;
              end
            end
          end
        end
      end
      ST_DRAIN, ST_FINAL: begin
        reqWrite = 1'b1;
        reqValid = holding || !outEmpty;
        accept   = reqValid && !reqStall;
        strobe.storeAdv = accept;
        if (!holding && outEmpty)
          stateNext = (state == ST_DRAIN) ? resumeState : ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      resumeState <= ST_LD1;
      holding     <= 1'b0;
      done        <= 1'b0;
    end else begin
      state   <= stateNext;
      holding <= reqValid && reqStall;
      done    <= (stateNext == ST_IDLE) && (state != ST_IDLE);
      if (saveResume) resumeState <= state;
    end
  end
endmodule

// File: rtl/plfLoadStoreSeq.sv
module plfLoadStoreSeq
  import seqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SITE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SITE_W-1:0] siteCount,
  input  logic [ADDR_W-1:0] baseLeft,
  input  logic [ADDR_W-1:0] baseRight,
  input  logic [ADDR_W-1:0] baseScale,
  input  logic [ADDR_W-1:0] baseCount,
  input  logic [ADDR_W-1:0] baseResult,
  output logic              reqValid,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqAddr,
  input  logic              reqStall,
  input  logic [1:0]        opFull,
  input  logic              outAlmostFull,
  input  logic              outEmpty,
  output logic              done
);
  seqStrobe_t strobe;
  logic       lastWord, lastSite, startEmpty;

  seqCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .reqStall(reqStall),
    .opFull(opFull), .outAlmostFull(outAlmostFull), .outEmpty(outEmpty),
    .lastWord(lastWord), .lastSite(lastSite), .startEmpty(startEmpty),
    .strobe(strobe), .reqValid(reqValid), .reqWrite(reqWrite), .done(done)
  );

  seqDatapath #(.ADDR_W(ADDR_W), .SITE_W(SITE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .siteCountIn(siteCount),
    .baseLeftIn(baseLeft), .baseRightIn(baseRight), .baseScaleIn(baseScale),
    .baseCountIn(baseCount), .baseResultIn(baseResult), .reqAddr(reqAddr),
    .lastWord(lastWord), .lastSite(lastSite), .startEmpty(startEmpty)
  );
endmodule

// File: rtl/plfLoadStoreSeqChk.sv
module plfLoadStoreSeqChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqStall,
  input logic [1:0]        opFull,
  input logic              outAlmostFull,
  input logic              outEmpty,
  input logic              done
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid && reqStall) |-> (reqValid && $stable(reqAddr) && $stable(reqWrite)));

  // R4
  opfull_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && (|opFull)) |-> $past(reqValid && reqStall));

  // R5
  almost_full_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && outAlmostFull) |-> $past(reqValid && reqStall));

  // R6
  empty_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && outEmpty) |-> $past(reqValid && reqStall));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !reqValid);
endmodule

bind plfLoadStoreSeq plfLoadStoreSeqChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqStall(reqStall), .opFull(opFull),
  .outAlmostFull(outAlmostFull), .outEmpty(outEmpty), .done(done)
);

// File: tb/plfLoadStoreSeq_tb.sv
module plfLoadStoreSeq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int SITE_W = 16;
  localparam logic [31:0] B_LEFT  = 32'h0001_0000;
  localparam logic [31:0] B_RIGHT = 32'h0002_0000;
  localparam logic [31:0] B_SCALE = 32'h0003_0000;
  localparam logic [31:0] B_COUNT = 32'h0004_0000;
  localparam logic [31:0] B_RES   = 32'h0008_0000;

  typedef struct packed {
    logic [7:0] sites;
    logic [7:0] stallMask;
    logic [7:0] opMask;
    logic [7:0] afLevel;   // 255 = never almost full
    logic       midStart;
  } scen_t;
  localparam int NSCEN = 5;
  localparam scen_t SCEN [NSCEN] = '{
    '{8'd3,  8'h00, 8'h00, 8'd255, 1'b0},
    '{8'd10, 8'h25, 8'h00, 8'd4,   1'b1},
    '{8'd7,  8'h00, 8'h91, 8'd3,   1'b0},
    '{8'd12, 8'h6C, 8'h42, 8'd2,   1'b1},
    '{8'd5,  8'hFE, 8'h10, 8'd1,   1'b0}
  };

  logic              clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [SITE_W-1:0] siteCount = '0;
  logic              reqValid, reqWrite, done;
  logic [ADDR_W-1:0] reqAddr;
  logic              reqStall = 1'b0, outAlmostFull = 1'b0, outEmpty = 1'b1;
  logic [1:0]        opFull = 2'b00;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plfLoadStoreSeq #(.ADDR_W(ADDR_W), .SITE_W(SITE_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .siteCount(siteCount),
    .baseLeft(B_LEFT), .baseRight(B_RIGHT), .baseScale(B_SCALE),
    .baseCount(B_COUNT), .baseResult(B_RES), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqStall(reqStall),
    .opFull(opFull), .outAlmostFull(outAlmostFull), .outEmpty(outEmpty),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input int n);
    int k = n / 6;
    case (n % 6)
      0: return B_LEFT  + 32'(16*k);
      1: return B_LEFT  + 32'(16*k + 8);
      2: return B_RIGHT + 32'(16*k);
      3: return B_RIGHT + 32'(16*k + 8);
      4: return B_SCALE + 32'(4*k);
      default: return B_COUNT + 32'(4*k);
    endcase
  endfunction

  task automatic runScen(input scen_t s);
    int  loadIdx = 0, writeIdx = 0, outCount = 0, earlyWrites = 0, doneCnt = 0;
    bit  prevHeld = 0, prevWrite = 0;
    logic [31:0] prevAddr = '0;
    int  total = 6 * int'(s.sites);
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      start         = (cyc == 0) || (s.midStart && cyc == 20);
      siteCount     = (cyc == 0) ? SITE_W'(s.sites) : SITE_W'(99);  // R10
      reqStall      = s.stallMask[cyc % 8];
      opFull        = {s.opMask[(cyc + 5) % 8], s.opMask[cyc % 8]};
      outAlmostFull = (outCount >= int'(s.afLevel));
      outEmpty      = (outCount == 0);
      #1;
      if (done) begin doneCnt++; break; end
      if (prevHeld) begin  // R3
        check(reqValid && reqAddr == prevAddr && reqWrite == prevWrite,
              "R3 held request", reqAddr, prevAddr);
      end
      if (reqValid && !reqStall) begin
        if (!reqWrite) begin
          // R2 R7 R10 exact order, nothing skipped or repeated
          check(loadIdx < total && reqAddr == expAddr(loadIdx), "R2/R7 load address",
                reqAddr, expAddr(loadIdx));
          check(!(outAlmostFull && !prevHeld), "R5 load while almost full", 1, 0);
          check(!((|opFull) && !prevHeld), "R4 load while operand fifo full", 1, 0);
          loadIdx++;
          if (loadIdx % 6 == 0) outCount++;
        end else begin
          // R6
          check(reqAddr == B_RES + 32'(16*writeIdx) && outCount > 0, "R6 write address",
                reqAddr, B_RES + 32'(16*writeIdx));
          writeIdx++;
          outCount--;
          if (loadIdx < total) earlyWrites++;
        end
      end
      prevHeld  = reqValid && reqStall;
      prevAddr  = reqAddr;
      prevWrite = reqWrite;
    end
    start = 1'b0;
    check(doneCnt == 1, "R8 done seen (watchdog)", doneCnt, 1);
    check(loadIdx == total, "R2/R7/R10 load count", loadIdx, total);
    check(writeIdx == int'(s.sites), "R8 write count", writeIdx, s.sites);
    if (int'(s.afLevel) < int'(s.sites))
      check(earlyWrites > 0, "R5 drain before last load", earlyWrites, 1);
    @(negedge clk);
    #1;
    check(!done && !reqValid, "R8 done one cycle", {done, reqValid}, 0);
  endtask

  initial begin
    // R1 reset and idle
    outEmpty = 1'b0;
    outAlmostFull = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!reqValid && !done, "R1 in reset", {reqValid, done}, 0);
    rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      #1;
      check(!reqValid && !done, "R1 idle", {reqValid, done}, 0);
    end
    outAlmostFull = 1'b0;
    outEmpty = 1'b1;

    foreach (SCEN[i]) runScen(SCEN[i]);

    // R9 zero sites
    runScen('{8'd0, 8'h0F, 8'h00, 8'd255, 1'b0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule